// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Router

This block collects a parameterised set of level-sensitive interrupt sources and steers each one to up to four processor cores. Every source has a routing register that picks the target core or cores. Every source also has a global enable bit, and each core keeps its own mask bit for each source. One designated source is a per-core timer line. It ignores the global enable and is gated only by each core's own mask.

Software never edits a bitmap of enables or masks. To change one bit, it writes the source index to a set register or a clear register. The bus has two windows. The global window holds the control word, the enable set/clear registers and the routing table. The per-core window holds the mask set/clear registers and an acknowledge register, and the core is chosen by a core-id input. Reading the acknowledge register returns the lowest-numbered source that is currently eligible for that core. Each core also has a registered interrupt output, which is high while at least one source is eligible for it.

Top module: `mcpu_irq_ctrl`

## Requirements
- R1: After reset, every source is globally disabled and masked on every core, every routing register holds 4'b0001 (core 0), irq_o is all zero and the acknowledge read of each core returns 0x3FF even with all sources high.
- R2: A global read at offset 0x000 returns NUM_SRC in bits [11:2], with all other bits zero.
- R3: Writing index N to global offset 0x030 sets the global enable of source N, and writing N to 0x034 clears it. A written value of NUM_SRC or more changes no enable.
- R4: Writing N to per-core offset 0x048 masks source N for the core named by req_cpu only, and writing N to 0x04C unmasks it. A value of NUM_SRC or more changes no mask.
- R5: The routing register of source N sits at global offset 0x100 + 4*N. Bits [3:0] form a core bitmask (bit c selects core c) and read back, and bits [31:4] are ignored on write and read as zero.
- R6: Source TIMER_SRC (5 by default) is gated by the per-core mask and routing only, never by the global enable.
- R7: A per-core read at offset 0x044 returns, in bits [9:0], the lowest-numbered source that is high, routed to that core, unmasked and enabled (or timer), with bits [31:10] zero. It returns 0x3FF when no source qualifies, and reading it has no side effect.
- R8: irq_o[c] is a flop. It shows at each rising edge whether any source was eligible for core c just before that edge, so it follows a source level change one edge later and deasserts when the level drops.
- R9: Read data and rd_valid appear on the rising edge that follows the edge sampling the read request. rd_valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| req_valid | input | 1 | Bus request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_percpu | input | 1 | 1 = per-core window, 0 = global window |
| req_cpu | input | 2 | Core id selecting the per-core window |
| req_addr | input | 16 | Byte offset within the selected window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_o | output | NUM_CPU | Registered interrupt request per core |

## Verification
A register write takes effect at the edge that samples it. Because irq_o is registered, an output that depends on a configuration write is due one edge after that. An output that depends on a source level change is due at the first edge after the change. The bench drives inputs on falling edges and waits two falling edges after a write before comparing irq_o. It also includes a single-edge probe that toggles the timer source and checks irq_o at the very next falling edge. Read results are due one edge after the request, so the driver pushes each expected word into a queue, and a monitor compares it at the falling edge where rd_valid shows, which also checks the R9 latency.

// File: rtl/mcpu_irq_pkg.sv
package mcpu_irq_pkg;
   localparam int ADDR_W    = 16;
   localparam int DATA_W    = 32;
   localparam int ID_W      = 10;
   localparam int CPU_ID_W  = 2;
   localparam int ROUTE_W   = 4;

   localparam logic [ADDR_W-1:0] OFS_CTRL       = 16'h000;
   localparam logic [ADDR_W-1:0] OFS_ENA_SET    = 16'h030;
   localparam logic [ADDR_W-1:0] OFS_ENA_CLR    = 16'h034;
   localparam logic [ADDR_W-1:0] OFS_ACK        = 16'h044;
   localparam logic [ADDR_W-1:0] OFS_MSK_SET    = 16'h048;
   localparam logic [ADDR_W-1:0] OFS_MSK_CLR    = 16'h04C;
   localparam logic [ADDR_W-1:0] OFS_ROUTE_BASE = 16'h100;

   localparam logic [ID_W-1:0] ID_NONE = 10'h3FF;

   typedef struct packed {
      logic              ena_set;
      logic              ena_clr;
      logic              msk_set;
      logic              msk_clr;
      logic              route_we;
      logic [ID_W-1:0]   wr_id;
      logic [ID_W-1:0]   route_id;
      logic              route_hit;
   } wr_decode_t;
endpackage

// File: rtl/mcpu_irq_decode.sv
module mcpu_irq_decode
   import mcpu_irq_pkg::*;
#(
   parameter int NUM_SRC = 32
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_percpu,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output wr_decode_t        dec_o
);
   localparam logic [ADDR_W-1:0] ROUTE_END = ADDR_W'(int'(OFS_ROUTE_BASE) + 4 * NUM_SRC);

   logic              wr_glb;
   logic              wr_pcpu;
   logic              id_ok;
   logic [ADDR_W-1:0] route_ofs;

   always_comb begin
      wr_glb    = req_valid && req_write && !req_percpu;
      wr_pcpu   = req_valid && req_write && req_percpu;
      id_ok     = req_wdata < DATA_W'(NUM_SRC);
      route_ofs = req_addr - OFS_ROUTE_BASE;

      dec_o           = '0;
      dec_o.wr_id     = req_wdata[ID_W-1:0];
      dec_o.ena_set   = wr_glb  && id_ok && (req_addr == OFS_ENA_SET);
      dec_o.ena_clr   = wr_glb  && id_ok && (req_addr == OFS_ENA_CLR);
      dec_o.msk_set   = wr_pcpu && id_ok && (req_addr == OFS_MSK_SET);
      dec_o.msk_clr   = wr_pcpu && id_ok && (req_addr == OFS_MSK_CLR);
      dec_o.route_hit = (req_addr >= OFS_ROUTE_BASE) && (req_addr < ROUTE_END) &&
                        (req_addr[1:0] == 2'b00);
      dec_o.route_id  = route_ofs[ID_W+1:2];
      dec_o.route_we  = wr_glb && dec_o.route_hit;
   end
endmodule

// File: rtl/mcpu_irq_srcbank.sv
module mcpu_irq_srcbank
   import mcpu_irq_pkg::*;
#(
   parameter int NUM_SRC = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  wr_decode_t                       dec_i,
   input  logic [ROUTE_W-1:0]               route_wdata,
   output logic [NUM_SRC-1:0]               ena_o,
   output logic [NUM_SRC-1:0][ROUTE_W-1:0]  route_o
);
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic hit_en;
      logic hit_rt;
      assign hit_en = (dec_i.wr_id    == ID_W'(s));
      assign hit_rt = (dec_i.route_id == ID_W'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ena_o[s]   <= 1'b0;
            route_o[s] <= ROUTE_W'(1);
         end else begin
            if (dec_i.ena_set && hit_en)
               ena_o[s] <= 1'b1;
            else if (dec_i.ena_clr && hit_en)
               ena_o[s] <= 1'b0;
            if (dec_i.route_we && hit_rt)
               route_o[s] <= route_wdata;
         end
      end
   end
endmodule

// File: rtl/mcpu_irq_cpuif.sv
module mcpu_irq_cpuif
   import mcpu_irq_pkg::*;
#(
   parameter int NUM_SRC      = 32,
   parameter int TIMER_SRC    = 5,
   parameter bit TIMER_BYPASS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [NUM_SRC-1:0] ena_i,
   input  logic [NUM_SRC-1:0] routed_i,
   input  logic               sel_i,
   input  wr_decode_t         dec_i,
   output logic [ID_W-1:0]    ack_o,
   output logic               irq_o
);
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] gate;
   logic [NUM_SRC-1:0] elig;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic hit;
      assign hit = sel_i && (dec_i.wr_id == ID_W'(s));

      always_ff @(posedge clk) begin
         if (!rst_n)
            mask_q[s] <= 1'b1;
         else if (dec_i.msk_set && hit)
            mask_q[s] <= 1'b1;
         else if (dec_i.msk_clr && hit)
            mask_q[s] <= 1'b0;
      end

      if (TIMER_BYPASS && s == TIMER_SRC) begin : g_timer
         assign gate[s] = 1'b1;
      end else begin : g_shared
         assign gate[s] = ena_i[s];
      end

      assign elig[s] = src_i[s] && routed_i[s] && !mask_q[s] && gate[s];
   end

   always_comb begin
      ack_o = ID_NONE;
      for (int s = NUM_SRC - 1; s >= 0; s--)
         if (elig[s]) ack_o = ID_W'(s);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |elig;
   end
endmodule

// File: rtl/mcpu_irq_ctrl.sv
module mcpu_irq_ctrl
   import mcpu_irq_pkg::*;
#(
   parameter int NUM_SRC      = 32,
   parameter int NUM_CPU      = 4,
   parameter int TIMER_SRC    = 5,
   parameter bit TIMER_BYPASS = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC-1:0]    src_i,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic                  req_percpu,
   input  logic [CPU_ID_W-1:0]   req_cpu,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  rd_valid,
   output logic [DATA_W-1:0]     rd_data,
   output logic [NUM_CPU-1:0]    irq_o
);
   localparam logic [DATA_W-1:0] CTRL_WORD = DATA_W'(NUM_SRC) << 2;

   initial begin
      assert (NUM_CPU >= 1 && NUM_CPU <= ROUTE_W) else $error("NUM_CPU out of range");
      assert (NUM_SRC >= 2 && NUM_SRC < 1023) else $error("NUM_SRC out of range");
      assert (TIMER_SRC < NUM_SRC) else $error("TIMER_SRC out of range");
   end

   wr_decode_t                        dec;
   logic [NUM_SRC-1:0]                ena;
   logic [NUM_SRC-1:0][ROUTE_W-1:0]   route;
   logic [NUM_CPU-1:0][ID_W-1:0]      ack;
   logic [ID_W-1:0]                   ack_sel;
   logic [ROUTE_W-1:0]                route_sel;
   logic [DATA_W-1:0]                 rd_next;

   mcpu_irq_decode #(.NUM_SRC(NUM_SRC)) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_percpu(req_percpu),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .dec_o     (dec)
   );

   mcpu_irq_srcbank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .dec_i      (dec),
      .route_wdata(req_wdata[ROUTE_W-1:0]),
      .ena_o      (ena),
      .route_o    (route)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [NUM_SRC-1:0] routed;
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_rt
         assign routed[s] = route[s][c];
      end

      mcpu_irq_cpuif #(
         .NUM_SRC     (NUM_SRC),
         .TIMER_SRC   (TIMER_SRC),
         .TIMER_BYPASS(TIMER_BYPASS)
      ) u_cpu (
         .clk     (clk),
         .rst_n   (rst_n),
         .src_i   (src_i),
         .ena_i   (ena),
         .routed_i(routed),
         .sel_i   (req_cpu == CPU_ID_W'(c)),
         .dec_i   (dec),
         .ack_o   (ack[c]),
         .irq_o   (irq_o[c])
      );
   end

   always_comb begin
      ack_sel = ID_NONE;
      for (int c = 0; c < NUM_CPU; c++)
         if (req_cpu == CPU_ID_W'(c)) ack_sel = ack[c];
      route_sel = '0;
      for (int s = 0; s < NUM_SRC; s++)
         if (dec.route_id == ID_W'(s)) route_sel = route[s];

      rd_next = '0;
      if (req_percpu) begin
         if (req_addr == OFS_ACK) rd_next = DATA_W'(ack_sel);
      end else if (req_addr == OFS_CTRL) begin
         rd_next = CTRL_WORD;
      end else if (dec.route_hit) begin
         rd_next = DATA_W'(route_sel);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= req_valid && !req_write;
         if (req_valid && !req_write) rd_data <= rd_next;
      end
   end
endmodule

// File: rtl/mcpu_irq_chk.sv
module mcpu_irq_chk
   import mcpu_irq_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int NUM_CPU = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_SRC-1:0]  src_i,
   input logic                req_valid,
   input logic                req_write,
   input logic                req_percpu,
   input logic [ADDR_W-1:0]   req_addr,
   input logic                rd_valid,
   input logic [DATA_W-1:0]   rd_data,
   input logic [NUM_CPU-1:0]  irq_o
);
   logic [NUM_SRC-1:0] src_d;
   logic               ack_rd;
   logic               route_rd;

   assign ack_rd   = req_valid && !req_write && req_percpu && (req_addr == OFS_ACK);
   assign route_rd = req_valid && !req_write && !req_percpu && (req_addr >= OFS_ROUTE_BASE);

   always_ff @(posedge clk) src_d <= src_i;

   // R1: first edge out of reset leaves every request low
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (irq_o == '0));

   // R8: a request can only rise when some source was high
   assert_irq_needs_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_o & ~$past(irq_o)) != '0) |-> $past(|src_i));

   // R7: a reported source was high at the sampling edge
   assert_ack_is_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(ack_rd) && rd_data[ID_W-1:0] != ID_NONE)
         |-> (((src_d >> rd_data[ID_W-1:0]) & NUM_SRC'(1)) != '0));

   // R7: idle sources yield the empty code and upper bits stay clear
   assert_ack_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(ack_rd) && src_d == '0) |-> (rd_data == DATA_W'(ID_NONE)));

   // R5: routing readback has no bits above the core mask
   assert_route_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(route_rd)) |-> (rd_data[DATA_W-1:ROUTE_W] == '0));
endmodule

bind mcpu_irq_ctrl mcpu_irq_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_i     (src_i),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_percpu(req_percpu),
   .req_addr  (req_addr),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data),
   .irq_o     (irq_o)
);

// File: tb/tb_mcpu_irq_ctrl.sv
module tb_mcpu_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 32;
   localparam int NCPU = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NSRC-1:0]   src_i = '0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic              req_percpu = 1'b0;
   logic [1:0]        req_cpu = '0;
   logic [15:0]       req_addr = '0;
   logic [31:0]       req_wdata = '0;
   logic              rd_valid;
   logic [31:0]       rd_data;
   logic [NCPU-1:0]   irq_o;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mcpu_irq_ctrl #(.NUM_SRC(NSRC), .NUM_CPU(NCPU)) dut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i),
      .req_valid(req_valid), .req_write(req_write), .req_percpu(req_percpu),
      .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq_o)
   );

   // monitor: pops the scoreboard whenever read data shows up
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R9: unexpected read data %h, expected none", rd_data);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rd_data !== e.exp) begin
               errors++;
               $display("FAIL %s: read data %h, expected %h", e.tag, rd_data, e.exp);
            end
         end
      end
   end

   task automatic wr(input bit pcpu, input int cpu, input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_percpu = pcpu;
      req_cpu = 2'(cpu); req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input bit pcpu, input int cpu, input logic [15:0] a,
                     input logic [31:0] exp, input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_percpu = pcpu;
      req_cpu = 2'(cpu); req_addr = a;
      e.exp = exp; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
      checks++;
      if (rd_valid !== 1'b1) begin
         errors++;
         $display("FAIL R9: rd_valid %b one edge after read, expected 1", rd_valid);
      end
   endtask

   task automatic ack(input int cpu, input logic [31:0] exp, input string tag);
      rd(1'b1, cpu, 16'h044, exp, tag);
   endtask

   task automatic chk_irq(input logic [NCPU-1:0] exp, input string tag);
      checks++;
      if (irq_o !== exp) begin
         errors++;
         $display("FAIL %s: irq_o %b, expected %b", tag, irq_o, exp);
      end
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R9: %0d reads never answered, expected 0", sb.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      src_i = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      // R1: reset state with every source high
      chk_irq(4'b0000, "R1 reset irq");
      for (int c = 0; c < NCPU; c++) ack(c, 32'h3FF, "R1 reset ack");
      rd(1'b0, 0, 16'h100 + 16'(4*7), 32'h1, "R1 route default");
      // R2: control word
      rd(1'b0, 0, 16'h000, 32'(NSRC) << 2, "R2 ctrl");
      src_i = '0;

      // R3/R4: enable 9 and unmask on core 0
      wr(1'b0, 0, 16'h030, 9);
      wr(1'b1, 0, 16'h04C, 9);
      src_i[9] = 1'b1;
      settle();
      chk_irq(4'b0001, "R3 enable+unmask");
      ack(0, 9, "R7 ack core0");
      ack(1, 32'h3FF, "R5 not routed core1");

      // R5: route 9 to core 2, still masked there
      wr(1'b0, 0, 16'h100 + 16'(4*9), 32'h4);
      settle();
      chk_irq(4'b0000, "R4 masked on core2");
      wr(1'b1, 2, 16'h04C, 9);
      settle();
      chk_irq(4'b0100, "R5 routed core2");
      ack(2, 9, "R5 ack core2");
      rd(1'b0, 0, 16'h100 + 16'(4*9), 32'h4, "R5 route readback");

      // R7: lower number wins
      wr(1'b0, 0, 16'h030, 3);
      wr(1'b1, 2, 16'h04C, 3);
      wr(1'b0, 0, 16'h100 + 16'(4*3), 32'h4);
      src_i[3] = 1'b1;
      settle();
      ack(2, 3, "R7 lowest wins");

      // R3: disable 3, then out-of-range index
      wr(1'b0, 0, 16'h034, 3);
      settle();
      ack(2, 9, "R3 clear enable");
      wr(1'b0, 0, 16'h034, 32 + 9);
      settle();
      ack(2, 9, "R3 out-of-range clear ignored");
      wr(1'b1, 2, 16'h048, 32 + 9);
      settle();
      ack(2, 9, "R4 out-of-range mask ignored");

      // R6: timer source bypasses global enable
      src_i[5] = 1'b1;
      settle();
      chk_irq(4'b0100, "R6 timer still masked");
      wr(1'b1, 0, 16'h04C, 5);
      settle();
      chk_irq(4'b0101, "R6 timer unmasked");
      ack(0, 5, "R6 timer ack");
      wr(1'b0, 0, 16'h034, 5);
      settle();
      ack(0, 5, "R6 global clear no effect");
      wr(1'b1, 1, 16'h048, 5);
      settle();
      ack(0, 5, "R4 other core mask no effect");

      // R8: one-edge level tracking
      @(negedge clk);
      src_i[5] = 1'b0;
      @(negedge clk);
      chk_irq(4'b0100, "R8 drop one edge");
      ack(0, 32'h3FF, "R8 ack after drop");
      src_i[5] = 1'b1;
      @(negedge clk);
      chk_irq(4'b0101, "R8 rise one edge");

      // R4: mask 9 on core 2
      wr(1'b1, 2, 16'h048, 9);
      settle();
      chk_irq(4'b0001, "R4 mask set");
      ack(2, 32'h3FF, "R4 ack after mask");

      // R5: high write bits ignored
      wr(1'b0, 0, 16'h100 + 16'(4*9), 32'hFFFF_FFF2);
      rd(1'b0, 0, 16'h100 + 16'(4*9), 32'h2, "R5 upper bits dropped");
      settle();
      chk_irq(4'b0001, "R4 core1 still masked for 9");

      // R7: ack read has no side effect
      ack(0, 5, "R7 ack repeat 1");
      ack(0, 5, "R7 ack repeat 2");

      // R9: no stray read data on idle cycles
      settle();
      checks++;
      if (rd_valid !== 1'b0) begin
         errors++;
         $display("FAIL R9: rd_valid %b while idle, expected 0", rd_valid);
      end
      finish_run();
   end
endmodule